// File: doc/BRIEF.md
# Endian-Aware Alternating Host Data Port

This block is the host-facing 16-bit data window of a packet buffer. The host reaches the buffer through one data port with no address decode. Each host access takes the next piece of the stream, as with a FIFO. Inside the chip the buffer moves 32-bit words. The port therefore splits each word into two 16-bit host accesses on reads, and joins two 16-bit host writes into one word on writes.

A remote-transfer command strobe starts each transfer and resets the access phase to "even". Every accepted access then flips the phase between even and odd. A 16-bit configuration register chooses the lane order. When the register is zero, the lower half of the word travels first. When it is nonzero, the upper half travels first. The register value is sampled only when a command is issued, so one word is never split under two different orders. A status byte reports the active order in bit 7.

On reads, an even access pulls a fresh word from the internal valid/ready source, and the odd access returns the half that was kept. On writes, the even half is latched, and the odd access hands the assembled word to the internal sink.

Top module: `hostport_split16`

## Requirements
- R1: With no command in between, successive accepted accesses stream through successive words. Each internal word takes exactly two host accesses.
- R2: The first accepted data access after `cmd_start` is even. After that, accepted accesses alternate odd, even, odd, and so on.
- R3: With order register value zero (little order), the even access carries word bits [15:0] (byte1 upper, byte0 lower). The odd access carries bits [31:16] (byte3 upper, byte2 lower). This applies to both reads and writes.
- R4: With a nonzero order register value (big order), the even access carries word bits [31:16] (byte3 upper, byte2 lower). The odd access carries bits [15:0] (byte1 upper, byte0 lower). This applies to both reads and writes.
- R5: `status_o[7]` is 1 when big order is active and 0 when little order is active. `status_o[6:0]` are always 0.
- R6: `in_ready` is high only during an even read access. Read data appears on `host_rdata` one cycle after the read strobe.
- R7: An accepted odd write raises `out_valid` in the next cycle, with the assembled word on `out_word`.
- R8: A write to the order register changes the active order (and `status_o[7]`) only at the next `cmd_start`.
- R9: An even read while `in_valid` is low is not accepted. The phase stays even and `host_rdata` keeps its value.
- R10: While `out_valid` is high and `out_ready` is low, `out_word` holds steady and an odd write is refused, leaving the phase odd.
- R11: After reset, `host_rdata` is 0, `out_valid` is 0, `status_o` is 0, the phase is even and the order register is 0.
- R12: A cycle with both host strobes high, or with `cmd_start` high, accepts no data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the lane-order register |
| cfg_wdata | input | 16 | New lane-order register value |
| cmd_start | input | 1 | Remote transfer command strobe; resets the phase |
| host_rd | input | 1 | Host read strobe on the data port |
| host_wr | input | 1 | Host write strobe on the data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| in_word | input | 32 | Internal word for host reads |
| in_valid | input | 1 | `in_word` is available |
| in_ready | output | 1 | Port takes `in_word` this cycle |
| out_word | output | 32 | Assembled word from host writes |
| out_valid | output | 1 | `out_word` is pending |
| out_ready | input | 1 | Sink takes `out_word` |
| status_o | output | 8 | Status byte; bit 7 reports the active order |

## Verification
The assertions check on every cycle the following behaviour:
- the phase reset after a command;
- that a fetch comes only from an even read, never from the odd read that follows;
- that conflicting strobes accept nothing;
- that a pending write word stays held;
- that the status byte changes only at a command.

The lane contents themselves can only be shown by the bench's scenarios. The bench sweeps sixteen word patterns in both orders for reads and writes and compares each half arithmetically. It also shows the following:
- that an order change is deferred until the next command;
- the refusal of an even read with no word available;
- the refusal of an odd write against a full output.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_t;

  function automatic logic [15:0] first_half(input logic [31:0] w, input logic big);
    first_half = big ? w[31:16] : w[15:0];
  endfunction

  function automatic logic [15:0] second_half(input logic [31:0] w, input logic big);
    second_half = big ? w[15:0] : w[31:16];
  endfunction

  function automatic logic [31:0] join_halves(input logic [15:0] f, input logic [15:0] s,
                                              input logic big);
    join_halves = big ? {f, s} : {s, f};
  endfunction
endpackage

// File: rtl/hostport_ctrl.sv
module hostport_ctrl
  import hostport_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cmd_start,
  input  logic             acc_ok,
  output phase_t           phase,
  output logic             big_mode
);
  logic [CFG_W-1:0] cfg_q, cfg_d;
  phase_t           ph_q, ph_d;
  logic             mode_q, mode_d;

  always_comb begin
    cfg_d  = cfg_q;
    ph_d   = ph_q;
    mode_d = mode_q;
    if (cfg_we) cfg_d = cfg_wdata;
    if (cmd_start) begin
      ph_d   = PH_EVEN;
      mode_d = (cfg_q != '0);
    end else if (acc_ok) begin
      ph_d = (ph_q == PH_EVEN) ? PH_ODD : PH_EVEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ph_q   <= PH_EVEN;
      mode_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      ph_q   <= ph_d;
      mode_q <= mode_d;
    end
  end

  assign phase    = ph_q;
  assign big_mode = mode_q;
endmodule

// File: rtl/hostport_rd_path.sv
module hostport_rd_path
  import hostport_pkg::*;
#(
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ok,
  input  phase_t        phase,
  input  logic          big_mode,
  input  logic [WW-1:0] in_word,
  output logic [HW-1:0] rdata
);
  logic [HW-1:0] rdata_q, rdata_d;
  logic [HW-1:0] keep_q, keep_d;

  always_comb begin
    rdata_d = rdata_q;
    keep_d  = keep_q;
    if (rd_ok) begin
      if (phase == PH_EVEN) begin
        rdata_d = first_half(in_word, big_mode);
        keep_d  = second_half(in_word, big_mode);
      end else begin
        rdata_d = keep_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      keep_q  <= '0;
    end else begin
      rdata_q <= rdata_d;
      keep_q  <= keep_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/hostport_wr_path.sv
module hostport_wr_path
  import hostport_pkg::*;
#(
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  phase_t        phase,
  input  logic          big_mode,
  input  logic [HW-1:0] wdata,
  input  logic          out_ready,
  output logic [WW-1:0] out_word,
  output logic          out_valid
);
  logic [HW-1:0] half_q, half_d;
  logic [WW-1:0] word_q, word_d;
  logic          vld_q, vld_d;

  always_comb begin
    half_d = half_q;
    word_d = word_q;
    vld_d  = vld_q;
    if (vld_q && out_ready) vld_d = 1'b0;
    if (wr_ok) begin
      if (phase == PH_EVEN) begin
        half_d = wdata;
      end else begin
        word_d = join_halves(half_q, wdata, big_mode);
        vld_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign out_word  = word_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/hostport_split16.sv
module hostport_split16
  import hostport_pkg::*;
#(
  parameter int HW       = 16,
  parameter int CFG_W    = 16,
  parameter int STAT_W   = 8,
  parameter int MODE_BIT = 7,
  localparam int WW      = 2 * HW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cmd_start,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [HW-1:0]     host_wdata,
  output logic [HW-1:0]     host_rdata,
  input  logic [WW-1:0]     in_word,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WW-1:0]     out_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [STAT_W-1:0] status_o
);
  phase_t phase;
  logic   big_mode;
  logic   rd_req, wr_req, rd_ok, wr_ok;

  assign rd_req   = host_rd && !host_wr && !cmd_start;
  assign wr_req   = host_wr && !host_rd && !cmd_start;
  assign in_ready = rd_req && (phase == PH_EVEN);
  assign rd_ok    = rd_req && ((phase == PH_ODD) || in_valid);
  assign wr_ok    = wr_req && ((phase == PH_EVEN) || !out_valid || out_ready);

  hostport_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cmd_start (cmd_start),
    .acc_ok    (rd_ok || wr_ok),
    .phase     (phase),
    .big_mode  (big_mode)
  );

  hostport_rd_path #(.HW(HW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_ok    (rd_ok),
    .phase    (phase),
    .big_mode (big_mode),
    .in_word  (in_word),
    .rdata    (host_rdata)
  );

  hostport_wr_path #(.HW(HW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (wr_ok),
    .phase     (phase),
    .big_mode  (big_mode),
    .wdata     (host_wdata),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_valid (out_valid)
  );

  always_comb begin
    status_o           = '0;
    status_o[MODE_BIT] = big_mode;
  end
endmodule

// File: rtl/hostport_split16_chk.sv
module hostport_split16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_start,
  input logic        host_rd,
  input logic        host_wr,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] out_word,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  status_o
);
  AST_CMD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_start) && host_rd && !host_wr && !cmd_start) |-> in_ready); // R2
  AST_ODD_NOFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_ready && in_valid) && host_rd && !host_wr && !cmd_start) |-> !in_ready); // R6
  AST_FETCH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (host_rd && !host_wr)); // R6
  AST_CLASH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd && host_wr) || cmd_start) |-> !in_ready); // R12
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R10
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_start) |-> $stable(status_o[7])); // R8
  AST_STAT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:0] == 7'd0); // R5
endmodule

bind hostport_split16 hostport_split16_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .host_rd   (host_rd),
  .host_wr   (host_wr),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_word  (out_word),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .status_o  (status_o)
);

// File: tb/sim_hostport_split16.sv
`timescale 1ns/1ps
module sim_hostport_split16;
  logic        clk, rst_n;
  logic        cfg_we, cmd_start, host_rd, host_wr, in_valid, out_ready;
  logic [15:0] cfg_wdata, host_wdata, host_rdata;
  logic [31:0] in_word, out_word;
  logic        in_ready, out_valid;
  logic [7:0]  status_o;
  int          n_chk, n_bad;

  hostport_split16 u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd();
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic set_order(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(output logic [15:0] d, output logic fetched);
    @(negedge clk); host_rd = 1'b1; #1 fetched = in_ready;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  logic [15:0] d0, d1;
  logic        f0, f1;
  logic [31:0] w;

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cfg_we = 0; cmd_start = 0; host_rd = 0; host_wr = 0;
    in_valid = 1; out_ready = 1; cfg_wdata = 0; host_wdata = 0; in_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 rdata", host_rdata, 0);
    check("R11 out_valid", out_valid, 0);
    check("R11 status", status_o, 0);

    for (int m = 0; m < 2; m++) begin
      set_order(m[0] ? 16'h0100 : 16'h0000);
      cmd();
      check("R5 status", status_o, {m[0], 7'd0});
      // R1 R3 R4 R6 read sweep, no command between words
      for (int k = 0; k < 16; k++) begin
        w = (k + 1) * 32'h9E37_79B9;
        in_word = w;
        rd(d0, f0);
        in_word = ~w;
        rd(d1, f1);
        check(m[0] ? "R4 rd even" : "R3 rd even", d0, m[0] ? w[31:16] : w[15:0]);
        check(m[0] ? "R4 rd odd"  : "R3 rd odd",  d1, m[0] ? w[15:0] : w[31:16]);
        check("R6 fetch even", f0, 1);
        check("R6 no fetch odd", f1, 0);
      end
      // R7 R3 R4 write sweep
      cmd();
      for (int k = 0; k < 16; k++) begin
        w = (k + 3) * 32'h85EB_CA6B;
        wr(m[0] ? w[31:16] : w[15:0]);
        check("R7 no push on even", out_valid, 0);
        wr(m[0] ? w[15:0] : w[31:16]);
        check("R7 valid", out_valid, 1);
        check(m[0] ? "R4 wr word" : "R3 wr word", out_word, w);
      end
    end

    // R8 order change deferred until command (currently big)
    set_order(16'h0000);
    check("R8 status before cmd", status_o, 8'h80);
    in_word = 32'hA1B2_C3D4;
    rd(d0, f0); rd(d1, f1);
    check("R8 still big even", d0, 16'hA1B2);
    check("R8 still big odd", d1, 16'hC3D4);
    cmd();
    check("R8 status after cmd", status_o, 8'h00);

    // R2 command mid-word resets phase
    in_word = 32'h1111_2222;
    rd(d0, f0);
    cmd();
    in_word = 32'h3333_4444;
    rd(d0, f0);
    check("R2 even after cmd fetch", f0, 1);
    check("R2 even after cmd data", d0, 16'h4444);
    rd(d1, f1);
    check("R2 odd data", d1, 16'h3333);

    // R9 even read without a word
    in_valid = 1'b0; in_word = 32'hDEAD_BEEF;
    rd(d0, f0);
    check("R9 rdata held", d0, 16'h3333);
    in_valid = 1'b1; in_word = 32'h5555_6666;
    rd(d0, f0);
    check("R9 phase still even", d0, 16'h6666);
    rd(d1, f1);
    check("R9 odd", d1, 16'h5555);

    // R12 both strobes ignored
    cmd();
    @(negedge clk); host_rd = 1; host_wr = 1; #1 check("R12 no fetch", in_ready, 0);
    @(negedge clk); host_rd = 0; host_wr = 0;
    check("R12 no push", out_valid, 0);
    in_word = 32'h7777_8888;
    rd(d0, f0);
    check("R12 phase still even", d0, 16'h8888);

    // R10 back-pressure
    cmd();
    out_ready = 1'b0;
    wr(16'h00AA); wr(16'h00BB);
    check("R10 valid", out_valid, 1);
    check("R10 word", out_word, 32'h00BB_00AA);
    wr(16'h0011); wr(16'h0022);
    check("R10 held word", out_word, 32'h00BB_00AA);
    check("R10 held valid", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", out_valid, 0);
    wr(16'h0033);
    check("R10 phase stayed odd", out_word, 32'h0033_0011);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule